// File: doc/BRIEF.md
# Superscalar Dispatch Group Controller

This block sits between an in-order front queue of decoded instructions and the out-of-order back end. The oldest instructions waiting in the queue are shown on a set of lanes, lane 0 being the oldest. In each cycle the block works out the longest in-order run of them that may enter the back end together. It raises a dispatch strobe for each accepted lane, so the queue knows how many entries to pop. Each instruction brings its micro-op count, its number of destination registers, the scheduler it targets, whether it loads or stores, and a flag that forces it to dispatch alone. The back-end structures report their free capacity as credit counts.

Each cycle the block reports a single stall cause: the reason the first lane that was refused could not go. It keeps a saturating counter for each stall cause. It also keeps a histogram of how many micro-ops each cycle dispatched. Both sets of counters are readable as flat output vectors, and both clear on reset.

Top module: `dispatch_ctrl`

## Requirements
- R1: Lanes are accepted strictly in order. Lane i is dispatched only if it is valid and every lane below it is dispatched. The first invalid lane, or the first refused lane, ends the group.
- R2: The micro-ops of a group never exceed the width W. W equals DISP_WIDTH, or DEF_WIDTH when DISP_WIDTH is 0. A lane refused only because it would pass W leaves the stall cause at 0.
- R3: The micro-ops accumulated up to and including a lane must not exceed rob_free. Otherwise the lane is refused with cause 1.
- R4: The destination registers accumulated up to and including a lane must not exceed reg_free. Otherwise the lane is refused with cause 2. When POOL_SIZE is 0 this check is skipped entirely.
- R5: Each lane takes as many entries as it has micro-ops from the scheduler that slot_sched selects. The entries accumulated per scheduler must not exceed that scheduler's field of sched_free (scheduler s occupies bits [s*CRED_W +: CRED_W]). Otherwise the lane is refused with cause 3.
- R6: A load lane takes one load-queue entry and a store lane takes one store-queue entry. Running past lq_free refuses the lane with cause 4; running past sq_free refuses it with cause 5.
- R7: A lane flagged solo may dispatch only from lane 0. No lane may follow a solo lane in the same group. A lane refused for either reason gets cause 6.
- R8: stall_cause names the first lane that is refused. The checks are applied in the order width (no cause), 1, 2, 3, 4, 5, 6. The cause is 0 when every lane dispatches, when the group ends at an invalid lane, or when the width ends it.
- R9: Counter j of stall_cnt (bits [j*CNT_W +: CNT_W]) increments in every cycle whose stall_cause equals j+1.
- R10: Histogram bin N of hist_cnt (bits [N*CNT_W +: CNT_W], N from 0 to W) increments in every cycle that dispatches exactly N micro-ops.
- R11: All counters stop at their all-ones value instead of wrapping.
- R12: A clock edge with rst_n low clears every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld | input | W | Lane holds an instruction |
| slot_uops | input | W*UOP_W | Micro-op count per lane (1 to W) |
| slot_dsts | input | W*REG_W | Destination register count per lane |
| slot_sched | input | W*SCH_IW | Target scheduler index per lane |
| slot_ld | input | W | Lane is a load |
| slot_st | input | W | Lane is a store |
| slot_solo | input | W | Lane must dispatch alone |
| rob_free | input | CRED_W | Free reorder-buffer entries |
| reg_free | input | CRED_W | Free rename registers |
| sched_free | input | NSCHED*CRED_W | Free entries per scheduler |
| lq_free | input | CRED_W | Free load-queue entries |
| sq_free | input | CRED_W | Free store-queue entries |
| disp_vld | output | W | Lane dispatched this cycle |
| stall_cause | output | 3 | Cause code 0 to 6 of the first refused lane |
| stall_cnt | output | 6*CNT_W | Saturating stall counters, one per cause |
| hist_cnt | output | (W+1)*CNT_W | Saturating micro-op-per-cycle histogram |

## Verification
The bench aims at the following faults:
- A lane that would still fit behind a refused older lane. A design that reorders would dispatch it.
- A lane past an invalid hole in the queue.
- A group that ends at the width. A design that wrongly charges it would count a stall there.
- A lane short of two resources at once. A design with the wrong priority would charge the later cause.
- A solo flag on lane 0 or on a later lane. A design that ignores it would merge the group.
- A second instance built with an unlimited register pool. A design that still applied the register check would refuse lanes there.
- A long run of empty cycles that drives the zero bin to its limit. A wrapping counter would show a small value.
- A reset in mid-run, which must leave every counter at zero.

// File: rtl/dispatch_pkg.sv
// Shared definitions for the dispatch group controller.
// Assumes: cause codes are fixed; the counters index them as code minus one.
package dispatch_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_ROB   = 3'd1,
        CAUSE_REG   = 3'd2,
        CAUSE_SCHED = 3'd3,
        CAUSE_LQ    = 3'd4,
        CAUSE_SQ    = 3'd5,
        CAUSE_GROUP = 3'd6
    } cause_e;

    localparam int NUM_CAUSES = 6;

endpackage

// File: rtl/dispatch_select.sv
// Combinational group former: walks the lanes oldest first, accumulates
// resource demand and stops at the first lane that fails a check.
// Assumes: each valid lane has 1..W micro-ops and a scheduler index below NSCHED.
module dispatch_select
    import dispatch_pkg::*;
#(
    parameter int W         = 4,
    parameter int UOP_W     = 3,
    parameter int REG_W     = 2,
    parameter int CRED_W    = 4,
    parameter int NSCHED    = 2,
    parameter int SCH_IW    = 1,
    parameter int POOL_SIZE = 32,
    parameter int GU_W      = 3
) (
    input  logic [W-1:0]             slot_vld,
    input  logic [W*UOP_W-1:0]       slot_uops,
    input  logic [W*REG_W-1:0]       slot_dsts,
    input  logic [W*SCH_IW-1:0]      slot_sched,
    input  logic [W-1:0]             slot_ld,
    input  logic [W-1:0]             slot_st,
    input  logic [W-1:0]             slot_solo,
    input  logic [CRED_W-1:0]        rob_free,
    input  logic [CRED_W-1:0]        reg_free,
    input  logic [NSCHED*CRED_W-1:0] sched_free,
    input  logic [CRED_W-1:0]        lq_free,
    input  logic [CRED_W-1:0]        sq_free,
    output logic [W-1:0]             disp_vld,
    output cause_e                   cause,
    output logic [GU_W-1:0]          grp_uops
);

    localparam bit REG_LIMITED = (POOL_SIZE != 0);

    int acc_u;
    int acc_r;
    int acc_l;
    int acc_s;
    int acc_q [NSCHED];
    int lane_u;
    int lane_r;
    int sidx;
    logic open;

    // Walk lanes in program order, accept while every check passes.
    always_comb begin
        acc_u    = 0;
        acc_r    = 0;
        acc_l    = 0;
        acc_s    = 0;
        lane_u   = 0;
        lane_r   = 0;
        sidx     = 0;
        open     = 1'b1;
        cause    = CAUSE_NONE;
        disp_vld = '0;
        for (int q = 0; q < NSCHED; q++) begin
            acc_q[q] = 0;
        end
        for (int i = 0; i < W; i++) begin
            lane_u = int'(slot_uops[i*UOP_W +: UOP_W]);
            lane_r = int'(slot_dsts[i*REG_W +: REG_W]);
            sidx   = int'(slot_sched[i*SCH_IW +: SCH_IW]);
            if (sidx >= NSCHED) begin
                sidx = 0;
            end
            if (open) begin
                if (!slot_vld[i]) begin
                    open = 1'b0;
                end else if (acc_u + lane_u > W) begin
                    open = 1'b0;
                end else if (acc_u + lane_u > int'(rob_free)) begin
                    open  = 1'b0;
                    cause = CAUSE_ROB;
                end else if (REG_LIMITED && (acc_r + lane_r > int'(reg_free))) begin
                    open  = 1'b0;
                    cause = CAUSE_REG;
                end else if (acc_q[sidx] + lane_u >
                             int'(sched_free[sidx*CRED_W +: CRED_W])) begin
                    open  = 1'b0;
                    cause = CAUSE_SCHED;
                end else if (slot_ld[i] && (acc_l + 1 > int'(lq_free))) begin
                    open  = 1'b0;
                    cause = CAUSE_LQ;
                end else if (slot_st[i] && (acc_s + 1 > int'(sq_free))) begin
                    open  = 1'b0;
                    cause = CAUSE_SQ;
                end else if ((i != 0) && (slot_solo[i] || slot_solo[0])) begin
                    open  = 1'b0;
                    cause = CAUSE_GROUP;
                end else begin
                    disp_vld[i] = 1'b1;
                    acc_u       = acc_u + lane_u;
                    acc_r       = acc_r + lane_r;
                    acc_q[sidx] = acc_q[sidx] + lane_u;
                    acc_l       = acc_l + (slot_ld[i] ? 1 : 0);
                    acc_s       = acc_s + (slot_st[i] ? 1 : 0);
                end
            end
        end
        grp_uops = GU_W'(acc_u);
    end

endmodule

// File: rtl/dispatch_sat_counter.sv
// Saturating event counter with synchronous active-low clear.
// Assumes: inc is a single-cycle event strobe.
module dispatch_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Count events, holding at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dispatch_stats.sv
// Statistics bank: one saturating counter per stall cause and one per
// histogram bin of micro-ops dispatched in a cycle.
// Assumes: grp_uops never exceeds W.
module dispatch_stats
    import dispatch_pkg::*;
#(
    parameter int W     = 4,
    parameter int GU_W  = 3,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  cause_e                      cause,
    input  logic [GU_W-1:0]             grp_uops,
    output logic [NUM_CAUSES*CNT_W-1:0] stall_cnt,
    output logic [(W+1)*CNT_W-1:0]      hist_cnt
);

    genvar k;
    generate
        for (k = 0; k < NUM_CAUSES; k++) begin : g_cause
            logic hit;
            // Strobe when this cycle is charged to cause k+1.
            always_comb hit = (3'(cause) == 3'(k + 1));
            dispatch_sat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (hit),
                .cnt   (stall_cnt[k*CNT_W +: CNT_W])
            );
        end
        for (k = 0; k <= W; k++) begin : g_bin
            logic hit;
            // Strobe when exactly k micro-ops went out this cycle.
            always_comb hit = (grp_uops == GU_W'(k));
            dispatch_sat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (hit),
                .cnt   (hist_cnt[k*CNT_W +: CNT_W])
            );
        end
    endgenerate

endmodule

// File: rtl/dispatch_ctrl.sv
// Dispatch group controller top: forms one in-order group per cycle from
// the front-queue lanes, reports the stall cause, keeps statistics.
// Assumes: lanes are the oldest queue entries, lane 0 oldest; credit inputs
// reflect capacity free at the start of the cycle.
module dispatch_ctrl
    import dispatch_pkg::*;
#(
    parameter int  DEF_WIDTH  = 4,
    parameter int  DISP_WIDTH = 0,
    parameter int  UOP_W      = 3,
    parameter int  REG_W      = 2,
    parameter int  CRED_W     = 4,
    parameter int  NSCHED     = 2,
    parameter int  POOL_SIZE  = 32,
    parameter int  CNT_W      = 16,
    localparam int W          = (DISP_WIDTH == 0) ? DEF_WIDTH : DISP_WIDTH,
    localparam int SCH_IW     = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                slot_vld,
    input  logic [W*UOP_W-1:0]          slot_uops,
    input  logic [W*REG_W-1:0]          slot_dsts,
    input  logic [W*SCH_IW-1:0]         slot_sched,
    input  logic [W-1:0]                slot_ld,
    input  logic [W-1:0]                slot_st,
    input  logic [W-1:0]                slot_solo,
    input  logic [CRED_W-1:0]           rob_free,
    input  logic [CRED_W-1:0]           reg_free,
    input  logic [NSCHED*CRED_W-1:0]    sched_free,
    input  logic [CRED_W-1:0]           lq_free,
    input  logic [CRED_W-1:0]           sq_free,
    output logic [W-1:0]                disp_vld,
    output logic [2:0]                  stall_cause,
    output logic [NUM_CAUSES*CNT_W-1:0] stall_cnt,
    output logic [(W+1)*CNT_W-1:0]      hist_cnt
);

    localparam int GU_W = $clog2(W + 1);

    cause_e          cause;
    logic [GU_W-1:0] grp_uops;

    dispatch_select #(
        .W         (W),
        .UOP_W     (UOP_W),
        .REG_W     (REG_W),
        .CRED_W    (CRED_W),
        .NSCHED    (NSCHED),
        .SCH_IW    (SCH_IW),
        .POOL_SIZE (POOL_SIZE),
        .GU_W      (GU_W)
    ) u_sel (
        .slot_vld   (slot_vld),
        .slot_uops  (slot_uops),
        .slot_dsts  (slot_dsts),
        .slot_sched (slot_sched),
        .slot_ld    (slot_ld),
        .slot_st    (slot_st),
        .slot_solo  (slot_solo),
        .rob_free   (rob_free),
        .reg_free   (reg_free),
        .sched_free (sched_free),
        .lq_free    (lq_free),
        .sq_free    (sq_free),
        .disp_vld   (disp_vld),
        .cause      (cause),
        .grp_uops   (grp_uops)
    );

    // Expose the cause code as a plain vector.
    always_comb stall_cause = 3'(cause);

    dispatch_stats #(
        .W     (W),
        .GU_W  (GU_W),
        .CNT_W (CNT_W)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .grp_uops  (grp_uops),
        .stall_cnt (stall_cnt),
        .hist_cnt  (hist_cnt)
    );

endmodule

// File: rtl/dispatch_ctrl_chk.sv
// Property checker for dispatch_ctrl, attached by bind below.
// Assumes: same parameters as the bound instance.
module dispatch_ctrl_chk #(
    parameter int  DEF_WIDTH  = 4,
    parameter int  DISP_WIDTH = 0,
    parameter int  UOP_W      = 3,
    parameter int  REG_W      = 2,
    parameter int  CRED_W     = 4,
    parameter int  NSCHED     = 2,
    parameter int  POOL_SIZE  = 32,
    parameter int  CNT_W      = 16,
    localparam int W          = (DISP_WIDTH == 0) ? DEF_WIDTH : DISP_WIDTH,
    localparam int SCH_IW     = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [W-1:0]             slot_vld,
    input logic [W*UOP_W-1:0]       slot_uops,
    input logic [W*REG_W-1:0]       slot_dsts,
    input logic [W*SCH_IW-1:0]      slot_sched,
    input logic [W-1:0]             slot_ld,
    input logic [W-1:0]             slot_st,
    input logic [W-1:0]             slot_solo,
    input logic [CRED_W-1:0]        rob_free,
    input logic [CRED_W-1:0]        reg_free,
    input logic [NSCHED*CRED_W-1:0] sched_free,
    input logic [CRED_W-1:0]        lq_free,
    input logic [CRED_W-1:0]        sq_free,
    input logic [W-1:0]             disp_vld,
    input logic [2:0]               stall_cause,
    input logic [6*CNT_W-1:0]       stall_cnt,
    input logic [(W+1)*CNT_W-1:0]   hist_cnt
);

    localparam int NCNT = 6 + W + 1;

    int du;
    int dl;
    int ds;
    logic [NCNT*CNT_W-1:0] all_cnt;

    // Tally what the dispatched lanes consume.
    always_comb begin
        du = 0;
        dl = 0;
        ds = 0;
        for (int i = 0; i < W; i++) begin
            if (disp_vld[i]) begin
                du = du + int'(slot_uops[i*UOP_W +: UOP_W]);
                dl = dl + (slot_ld[i] ? 1 : 0);
                ds = ds + (slot_st[i] ? 1 : 0);
            end
        end
        all_cnt = {hist_cnt, stall_cnt};
    end

    p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        du <= W);

    p_rob_r3: assert property (@(posedge clk) disable iff (!rst_n)
        du <= int'(rob_free));

    p_lsq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dl <= int'(lq_free)) && (ds <= int'(sq_free)));

    p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cause != 3'd0) |-> ((stall_cause <= 3'd6) && !(&disp_vld)));

    genvar g;
    generate
        for (g = 1; g < W; g++) begin : g_lane
            p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
                disp_vld[g] |-> (disp_vld[g-1] && slot_vld[g]));
            p_solo_r7: assert property (@(posedge clk) disable iff (!rst_n)
                disp_vld[g] |-> (!slot_solo[g] && !slot_solo[0]));
        end
        for (g = 0; g < NCNT; g++) begin : g_cnt
            p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((all_cnt[g*CNT_W +: CNT_W] == $past(all_cnt[g*CNT_W +: CNT_W])) ||
                          (all_cnt[g*CNT_W +: CNT_W] == $past(all_cnt[g*CNT_W +: CNT_W]) + 1'b1)));
            p_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (all_cnt[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}) |=>
                (all_cnt[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
            p_clear_r12: assert property (@(posedge clk)
                !rst_n |=> (all_cnt[g*CNT_W +: CNT_W] == '0));
        end
    endgenerate

endmodule

bind dispatch_ctrl dispatch_ctrl_chk #(
    .DEF_WIDTH  (DEF_WIDTH),
    .DISP_WIDTH (DISP_WIDTH),
    .UOP_W      (UOP_W),
    .REG_W      (REG_W),
    .CRED_W     (CRED_W),
    .NSCHED     (NSCHED),
    .POOL_SIZE  (POOL_SIZE),
    .CNT_W      (CNT_W)
) u_chk (.*);

// File: tb/tb_dispatch_ctrl.sv
// Bench for dispatch_ctrl: directed corners plus seeded random groups,
// compared against a behavioural model built from the requirements.
module tb_dispatch_ctrl;

    localparam int W      = 4;
    localparam int UOP_W  = 3;
    localparam int REG_W  = 2;
    localparam int CRED_W = 4;
    localparam int NSCHED = 2;
    localparam int SCH_IW = 1;
    localparam int CNT_W  = 8;
    localparam int MAXC   = 255;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]             slot_vld   = '0;
    logic [W*UOP_W-1:0]       slot_uops  = '0;
    logic [W*REG_W-1:0]       slot_dsts  = '0;
    logic [W*SCH_IW-1:0]      slot_sched = '0;
    logic [W-1:0]             slot_ld    = '0;
    logic [W-1:0]             slot_st    = '0;
    logic [W-1:0]             slot_solo  = '0;
    logic [CRED_W-1:0]        rob_free   = '0;
    logic [CRED_W-1:0]        reg_free   = '0;
    logic [NSCHED*CRED_W-1:0] sched_free = '0;
    logic [CRED_W-1:0]        lq_free    = '0;
    logic [CRED_W-1:0]        sq_free    = '0;
    logic [W-1:0]             disp_vld, np_disp;
    logic [2:0]               stall_cause, np_cause;
    logic [6*CNT_W-1:0]       stall_cnt, np_stall;
    logic [(W+1)*CNT_W-1:0]   hist_cnt, np_hist;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int m_stall [6];
    int m_hist  [W+1];

    always #4 clk = ~clk;

    dispatch_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_uops(slot_uops),
        .slot_dsts(slot_dsts), .slot_sched(slot_sched), .slot_ld(slot_ld),
        .slot_st(slot_st), .slot_solo(slot_solo), .rob_free(rob_free),
        .reg_free(reg_free), .sched_free(sched_free), .lq_free(lq_free),
        .sq_free(sq_free), .disp_vld(disp_vld), .stall_cause(stall_cause),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt));

    dispatch_ctrl #(.CNT_W(CNT_W), .POOL_SIZE(0)) dut_np (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_uops(slot_uops),
        .slot_dsts(slot_dsts), .slot_sched(slot_sched), .slot_ld(slot_ld),
        .slot_st(slot_st), .slot_solo(slot_solo), .rob_free(rob_free),
        .reg_free(reg_free), .sched_free(sched_free), .lq_free(lq_free),
        .sq_free(sq_free), .disp_vld(np_disp), .stall_cause(np_cause),
        .stall_cnt(np_stall), .hist_cnt(np_hist));

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Expected group and cause from the requirement text.
    function automatic void model(input bit unlim, output logic [W-1:0] m,
                                  output logic [2:0] c, output int nu);
        int au, ar, al, ast, s, u, r;
        int aq [NSCHED];
        bit stop;
        bit bl [7];
        m = '0; c = 3'd0; au = 0; ar = 0; al = 0; ast = 0; stop = 0;
        for (int q = 0; q < NSCHED; q++) aq[q] = 0;
        for (int i = 0; i < W; i++) begin
            if (stop) continue;
            if (!slot_vld[i]) begin stop = 1; continue; end
            u = int'(slot_uops[i*UOP_W +: UOP_W]);
            r = int'(slot_dsts[i*REG_W +: REG_W]);
            s = int'(slot_sched[i]);
            if (au + u > W) begin stop = 1; continue; end
            bl[1] = (au + u) > int'(rob_free);
            bl[2] = !unlim && ((ar + r) > int'(reg_free));
            bl[3] = (aq[s] + u) > int'(sched_free[s*CRED_W +: CRED_W]);
            bl[4] = slot_ld[i] && (al >= int'(lq_free));
            bl[5] = slot_st[i] && (ast >= int'(sq_free));
            bl[6] = (i > 0) && (slot_solo[i] || slot_solo[0]);
            for (int k = 6; k >= 1; k--) if (bl[k]) c = 3'(k);
            if (c != 3'd0) begin stop = 1; continue; end
            m[i] = 1'b1;
            au += u; ar += r; aq[s] += u;
            al += slot_ld[i] ? 1 : 0;
            ast += slot_st[i] ? 1 : 0;
        end
        nu = au;
    endfunction

    function automatic logic [63:0] pk_stall();
        logic [63:0] v = '0;
        for (int k = 0; k < 6; k++) v[k*CNT_W +: CNT_W] = CNT_W'(m_stall[k]);
        return v;
    endfunction

    function automatic logic [63:0] pk_hist();
        logic [63:0] v = '0;
        for (int k = 0; k <= W; k++) v[k*CNT_W +: CNT_W] = CNT_W'(m_hist[k]);
        return v;
    endfunction

    // One cycle: check counters, then group and cause, then advance the model.
    task automatic step(input string tag);
        logic [W-1:0] m, m2;
        logic [2:0] c, c2;
        int nu, nu2;
        chk(stall_cnt == pk_stall()[6*CNT_W-1:0], "R9", 64'(stall_cnt), pk_stall());
        chk(hist_cnt == pk_hist()[(W+1)*CNT_W-1:0], "R10", 64'(hist_cnt), pk_hist());
        #2;
        model(1'b0, m, c, nu);
        model(1'b1, m2, c2, nu2);
        chk(disp_vld == m, tag, 64'(disp_vld), 64'(m));
        chk(stall_cause == c, tag, 64'(stall_cause), 64'(c));
        chk(np_disp == m2, tag, 64'(np_disp), 64'(m2));
        @(posedge clk);
        #1;
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) m_stall[k] = 0;
            for (int k = 0; k <= W; k++) m_hist[k] = 0;
        end else begin
            if (c != 3'd0 && m_stall[c-1] < MAXC) m_stall[c-1]++;
            if (m_hist[nu] < MAXC) m_hist[nu]++;
        end
        @(negedge clk);
    endtask

    // Ample credits, empty queue.
    task automatic idle();
        slot_vld = '0; slot_uops = '0; slot_dsts = '0; slot_sched = '0;
        slot_ld = '0; slot_st = '0; slot_solo = '0;
        rob_free = 4'd15; reg_free = 4'd15; sched_free = {4'd15, 4'd15};
        lq_free = 4'd15; sq_free = 4'd15;
    endtask

    task automatic ones4();
        slot_vld = 4'b1111;
        slot_uops = {3'd1, 3'd1, 3'd1, 3'd1};
        slot_dsts = {2'd1, 2'd1, 2'd1, 2'd1};
    endtask

    task automatic rnd();
        int nv = int'($urandom % 5);
        slot_vld = 4'((1 << nv) - 1);
        for (int i = 0; i < W; i++) begin
            slot_uops[i*UOP_W +: UOP_W] = 3'(1 + $urandom % 3);
            slot_dsts[i*REG_W +: REG_W] = 2'($urandom % 4);
            slot_sched[i] = 1'($urandom % 2);
            slot_ld[i] = ($urandom % 3) == 0;
            slot_st[i] = ($urandom % 4) == 0;
            slot_solo[i] = ($urandom % 8) == 0;
        end
        rob_free = 4'($urandom % 11);
        reg_free = 4'($urandom % 9);
        sched_free = {4'($urandom % 9), 4'($urandom % 9)};
        lq_free = 4'($urandom % 3);
        sq_free = 4'($urandom % 3);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 6; k++) m_stall[k] = 0;
        for (int k = 0; k <= W; k++) m_hist[k] = 0;
        idle();
        repeat (3) @(negedge clk);
        chk(stall_cnt == '0, "R12", 64'(stall_cnt), 0);
        chk(hist_cnt == '0, "R12", 64'(hist_cnt), 0);
        rst_n = 1'b1;
        // R8 empty queue: nothing dispatched, no cause
        step("R8");
        // R1 four single-uop lanes all go
        ones4(); step("R1");
        // R1 hole at lane 2 ends the group
        slot_vld = 4'b1011; step("R1");
        // R2 width stop: 2+2 fits, the third lane does not, no cause
        ones4(); slot_uops = {3'd1, 3'd1, 3'd2, 3'd2}; step("R2");
        // R3 reorder buffer short after two lanes
        idle(); ones4(); rob_free = 4'd2; step("R3");
        // R4 rename registers: 2+2 > 3; unlimited pool dispatches all
        idle(); ones4(); slot_dsts = {2'd0, 2'd0, 2'd2, 2'd2}; reg_free = 4'd3; step("R4");
        // R5 scheduler 0 holds one entry, lane 1 also targets it
        idle(); ones4(); sched_free = {4'd15, 4'd1}; step("R5");
        // R1 older lane stalls on scheduler 0, younger for scheduler 1 stays
        idle(); ones4(); slot_sched = 4'b1110; sched_free = {4'd15, 4'd0}; step("R1");
        // R6 two loads, one load-queue entry
        idle(); ones4(); slot_ld = 4'b0011; lq_free = 4'd1; step("R6");
        // R6 stores, store queue empty
        idle(); ones4(); slot_st = 4'b0100; sq_free = 4'd0; step("R6");
        // R7 solo on lane 1, then solo on lane 0
        idle(); ones4(); slot_solo = 4'b0010; step("R7");
        slot_solo = 4'b0001; step("R7");
        // R8 lane 1 short of both ROB and LQ: ROB wins
        idle(); ones4(); rob_free = 4'd1; slot_ld = 4'b0011; lq_free = 4'd1; step("R8");
        // R8 lane 1 short of SQ and solo: SQ wins
        idle(); ones4(); slot_st = 4'b0010; sq_free = 4'd0; slot_solo = 4'b0010; step("R8");
        // random groups
        for (int n = 0; n < 3000; n++) begin
            rnd(); step("R9");
        end
        // R11 hold the queue empty until bin 0 saturates
        idle();
        for (int n = 0; n < 300; n++) step("R11");
        chk(hist_cnt[CNT_W-1:0] == 8'hFF, "R11", 64'(hist_cnt[CNT_W-1:0]), 64'hFF);
        // R10 a few full-width groups after saturation
        ones4(); step("R10"); step("R10");
        // R12 mid-run reset clears everything
        rst_n = 1'b0; step("R12");
        rst_n = 1'b1;
        chk(stall_cnt == '0, "R12", 64'(stall_cnt), 0);
        chk(hist_cnt == '0, "R12", 64'(hist_cnt), 0);
        step("R10");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule